// File: doc/BRIEF.md
# Prioritised DRAM Buffer Arbiter

This block decides which of several clients may use a single external DRAM buffer. The clients are five front-end write sources (frame bytes, error flags, subcode bytes, Q-channel bytes and the sector status byte), an embedded processor, a SCSI transfer engine and an ECC engine. A refresh client inside the block raises its own request at a fixed cycle interval. Exactly one client owns the buffer at a time. The DRAM timing generator downstream runs the access and pulses a completion strobe when it is done.

Arbitration happens at two points: on the clock edge after a request arrives while the buffer is idle, and on the edge where the completion strobe is high. Between those points the grant does not change. Priority is fixed, and the processor is placed inside the front-end chain. It ranks below frame and flag writes but above the other three front-end sources. A client whose access has just finished cannot win the next decision. The exceptions are SCSI and ECC while their burst flag is asserted: they keep the buffer with no gap until a client of higher rank asks for it. Refresh takes the buffer for one access and then gives it back.

Top module: `dram_buf_arbiter`

## Requirements
- R1: While reset is held, and after it is released with no request present, `grant` is all zero and `rfsh_gnt` is low.
- R2: When the buffer is idle and at least one request is present at a rising edge, the highest-ranked eligible client is granted at that same edge. At most one bit of {`rfsh_gnt`, `grant`} is ever set. Grant bit map: bits 0..4 are frame, flag, subcode, Q-channel and status; bit 5 is processor; bit 6 is SCSI; bit 7 is ECC.
- R3: While a grant is active and `cyc_done` is low, the grant holds its value.
- R4: Rank order, from highest to lowest: frame, flag, processor, subcode, Q-channel, status, refresh, SCSI, ECC.
- R5: When `cyc_done` ends an access, the client that held the buffer is not eligible at that decision. The one exception is R6. If another client is requesting, that client is granted. If no other client is requesting, the finishing client's own held request is granted at the next edge.
- R6: When `cyc_done` ends an SCSI access with `scsi_burst` high, or an ECC access with `ecc_burst` high, and that client is still requesting, it keeps the grant with no idle cycle. The continuation is pre-empted only by a request of higher rank.
- R7: A refresh request becomes pending every RFSH_CYCLES clocks, counted from reset release. A pending refresh waits for the current access to end. It is then granted under the R4 order for a single access, and `rfsh_gnt` is never granted twice in a row.
- R8: If no client is eligible when `cyc_done` ends an access, all grant outputs go low at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_req | input | FE_SRCS | Front-end requests: bit 0 frame, 1 flag, 2 subcode, 3 Q-channel, 4 status |
| cpu_req | input | 1 | Processor request |
| scsi_req | input | 1 | SCSI request |
| scsi_burst | input | 1 | SCSI wants to continue the burst after the current access |
| ecc_req | input | 1 | ECC request |
| ecc_burst | input | 1 | ECC wants to continue the burst after the current access |
| cyc_done | input | 1 | The current access finishes at this edge |
| grant | output | FE_SRCS+3 | One-hot client grant, with the bit map given in R2 |
| rfsh_gnt | output | 1 | Refresh access in progress |

## Verification
The RTL assertions are evaluated on every cycle. They check that the grant is one-hot, that it holds between completion strobes, that an idle buffer grants one edge after a request, that a waiting frame write wins any decision, that a burst continues when nothing of higher rank waits, and that refresh never takes two accesses in a row. The full rank order, the processor being interleaved inside the front-end chain, the exclusion of the finishing owner, the refresh interval and refresh pre-empting a running ECC burst are shown only by the bench. The bench's reference model follows the grant through directed sequences and a long pseudo-random run.

// File: rtl/dbarb_pkg.sv
package dbarb_pkg;

   // Map a rank position (0 = highest) to a source index in port order.
   // Port order: fe[0..F-1], cpu=F, scsi=F+1, ecc=F+2, refresh=F+3.
   // Rank order: fe[0..C-1], cpu, fe[C..F-1], refresh, scsi, ecc.
   function automatic int src_of_rank(input int r, input int f, input int c);
      if (r < c)          return r;
      else if (r == c)    return f;
      else if (r <= f)    return r - 1;
      else if (r == f+1)  return f + 3;
      else if (r == f+2)  return f + 1;
      else                return f + 2;
   endfunction

endpackage

// File: rtl/dbarb_rfsh_timer.sv
module dbarb_rfsh_timer #(
   parameter int RFSH_CYCLES = 528
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic pend
);
   localparam int CW = (RFSH_CYCLES > 2) ? $clog2(RFSH_CYCLES) : 1;

   if (RFSH_CYCLES < 2) begin : g_bad_period
      $error("RFSH_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          wrap;

   assign wrap = (cnt_q == CW'(RFSH_CYCLES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pend  <= 1'b0;
      end else begin
         cnt_q <= wrap ? '0 : cnt_q + 1'b1;
         if (wrap)      pend <= 1'b1;
         else if (clr)  pend <= 1'b0;
      end
   end

   // R7: a new refresh is raised only when the interval counter wraps
   a_r7_pend_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> ($past(cnt_q) == CW'(RFSH_CYCLES - 1)));
endmodule

// File: rtl/dbarb_rank_pick.sv
module dbarb_rank_pick
   import dbarb_pkg::*;
#(
   parameter int FE_SRCS  = 5,
   parameter int CPU_SLOT = 2,
   parameter int NSRC     = FE_SRCS + 4
) (
   input  logic [NSRC-1:0] elig,
   output logic [NSRC-1:0] pick
);
   logic [NSRC-1:0] by_rank;
   logic [NSRC-1:0] win_rank;

   for (genvar r = 0; r < NSRC; r++) begin : g_to_rank
      assign by_rank[r] = elig[src_of_rank(r, FE_SRCS, CPU_SLOT)];
   end

   always_comb begin
      win_rank = '0;
      for (int r = 0; r < NSRC; r++) begin
         if (by_rank[r] && (win_rank == '0)) win_rank[r] = 1'b1;
      end
   end

   for (genvar r = 0; r < NSRC; r++) begin : g_from_rank
      assign pick[src_of_rank(r, FE_SRCS, CPU_SLOT)] = win_rank[r];
   end

   // R2: winner is one-hot whenever anything is eligible
   always_comb begin
      a_r2_pick_onehot: assert ((elig == '0) || ($countones(pick) == 1));
   end
endmodule

// File: rtl/dram_buf_arbiter.sv
module dram_buf_arbiter
   import dbarb_pkg::*;
#(
   parameter int FE_SRCS     = 5,
   parameter int CPU_SLOT    = 2,
   parameter int RFSH_CYCLES = 528
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FE_SRCS-1:0] fe_req,
   input  logic               cpu_req,
   input  logic               scsi_req,
   input  logic               scsi_burst,
   input  logic               ecc_req,
   input  logic               ecc_burst,
   input  logic               cyc_done,
   output logic [FE_SRCS+2:0] grant,
   output logic               rfsh_gnt
);
   localparam int NSRC     = FE_SRCS + 4;
   localparam int IDX_CPU  = FE_SRCS;
   localparam int IDX_SCSI = FE_SRCS + 1;
   localparam int IDX_ECC  = FE_SRCS + 2;
   localparam int IDX_RF   = FE_SRCS + 3;

   if (FE_SRCS < 1 || CPU_SLOT < 0 || CPU_SLOT > FE_SRCS) begin : g_bad_cfg
      $error("CPU_SLOT must lie within 0..FE_SRCS and FE_SRCS >= 1");
   end

   logic [NSRC-1:0] own_q, req_v, elig, pick;
   logic            rf_pend, decide, cont;

   assign req_v  = {rf_pend, ecc_req, scsi_req, cpu_req, fe_req};
   assign cont   = (own_q[IDX_SCSI] & scsi_burst) | (own_q[IDX_ECC] & ecc_burst);
   assign decide = ~(|own_q) | cyc_done;
   assign elig   = req_v & ~(own_q & {NSRC{cyc_done & ~cont}});

   dbarb_rank_pick #(
      .FE_SRCS (FE_SRCS),
      .CPU_SLOT(CPU_SLOT),
      .NSRC    (NSRC)
   ) u_pick (
      .elig(elig),
      .pick(pick)
   );

   dbarb_rfsh_timer #(
      .RFSH_CYCLES(RFSH_CYCLES)
   ) u_rfsh (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (decide & pick[IDX_RF]),
      .pend (rf_pend)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      own_q <= '0;
      else if (decide) own_q <= pick;
   end

   assign grant    = own_q[NSRC-2:0];
   assign rfsh_gnt = own_q[IDX_RF];

   // R2: never more than one owner
   a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(own_q));
   // R2: idle buffer with a request grants at the next edge
   a_r2_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == '0) && (req_v != '0) |=> (own_q != '0));
   // R3: grant frozen until the completion strobe
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q != '0) && !cyc_done |=> $stable(own_q));
   // R4: a waiting frame write wins every decision it is eligible for
   a_r4_frame_top: assert property (@(posedge clk) disable iff (!rst_n)
      decide && fe_req[0] && !(own_q[0] && cyc_done) |=> own_q[0]);
   // R6: burst continues when nothing of higher rank waits
   a_r6_scsi_cont: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done && own_q[IDX_SCSI] && scsi_burst && scsi_req
      && (fe_req == '0) && !cpu_req && !rf_pend |=> own_q[IDX_SCSI]);
   // R7: refresh holds for one access only
   a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
      own_q[IDX_RF] && cyc_done |=> !own_q[IDX_RF]);
endmodule

// File: tb/tb_dram_buf_arbiter.sv
module tb_dram_buf_arbiter;
   localparam int RF  = 200;
   localparam int LEN = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] fe_req = '0;
   logic       cpu_req = 0, scsi_req = 0, scsi_burst = 0;
   logic       ecc_req = 0, ecc_burst = 0, cyc_done = 0;
   logic [7:0] grant;
   logic       rfsh_gnt;

   dram_buf_arbiter #(.FE_SRCS(5), .CPU_SLOT(2), .RFSH_CYCLES(RF)) dut (
      .clk(clk), .rst_n(rst_n), .fe_req(fe_req), .cpu_req(cpu_req),
      .scsi_req(scsi_req), .scsi_burst(scsi_burst), .ecc_req(ecc_req),
      .ecc_burst(ecc_burst), .cyc_done(cyc_done), .grant(grant), .rfsh_gnt(rfsh_gnt));

   always #4 clk = ~clk;

   int checks = 0, fails = 0;
   string tag = "R1";
   int order [9] = '{0, 1, 5, 2, 3, 4, 8, 6, 7};

   // behavioural reference model
   int m_own = -1, m_cnt = 0;
   bit m_pend = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_own = -1; m_cnt = 0; m_pend = 0;
      end else begin
         bit tick, cont;
         bit [8:0] rv;
         int nxt;
         tick = (m_cnt == RF - 1);
         rv = {m_pend, ecc_req, scsi_req, cpu_req, fe_req};
         if (m_own < 0 || cyc_done) begin
            cont = cyc_done && ((m_own == 6 && scsi_burst) || (m_own == 7 && ecc_burst));
            nxt = -1;
            foreach (order[k]) begin
               if (nxt < 0 && rv[order[k]] && !(cyc_done && order[k] == m_own && !cont))
                  nxt = order[k];
            end
            if (nxt == 8) m_pend = 0;
            m_own = nxt;
         end
         m_cnt = tick ? 0 : m_cnt + 1;
         if (tick) m_pend = 1;
      end
   end

   function automatic logic [8:0] vec_of(int o);
      return (o < 0) ? 9'd0 : 9'(1) << o;
   endfunction

   task automatic chk(input bit ok, input string t, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", t, act, exp, $time);
      end
   endtask

   int acnt = 0, prev_own = -1;
   bit prev_done = 0;

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk({rfsh_gnt, grant} == vec_of(m_own), tag, {rfsh_gnt, grant}, vec_of(m_own));
         if (m_own >= 0) begin
            if (m_own != prev_own || prev_done) acnt = 0;
            else acnt++;
            cyc_done = (acnt == LEN - 1);
         end else begin
            acnt = 0; cyc_done = 0;
         end
         prev_own = m_own; prev_done = cyc_done;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; fe_req = '0; cpu_req = 0; scsi_req = 0; scsi_burst = 0;
      ecc_req = 0; ecc_burst = 0; cyc_done = 0;
      acnt = 0; prev_own = -1; prev_done = 0;
      repeat (3) @(negedge clk);
      chk({rfsh_gnt, grant} == 9'd0, "R1 in reset", {rfsh_gnt, grant}, 9'd0);
      rst_n = 1;
   endtask

   function automatic logic [8:0] g();
      return {rfsh_gnt, grant};
   endfunction

   bit finished = 0;
   initial begin
      #(200000 * 8);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      int seen;
      logic [31:0] lf;
      // R1: reset and idle
      tag = "R1";
      do_reset();
      step(5);
      chk(g() == 9'd0, "R1 idle after reset", g(), 9'd0);

      // R2 / R3 / R8: lone processor access
      tag = "R2";
      cpu_req = 1; step(1);
      chk(g() == 9'h020, "R2 cpu granted next edge", g(), 9'h020);
      cpu_req = 0; tag = "R3"; step(2);
      chk(g() == 9'h020, "R3 grant held before done", g(), 9'h020);
      tag = "R8"; step(3);
      chk(g() == 9'd0, "R8 grant released when nothing waits", g(), 9'd0);

      // R4 / R5: rank order with processor interleave
      do_reset(); tag = "R4";
      fe_req = 5'h1F; cpu_req = 1; scsi_req = 1; ecc_req = 1;
      step(1);  chk(g() == 9'h001, "R4 frame first", g(), 9'h001);
      tag = "R5";
      step(5);  chk(g() == 9'h002, "R5 flag after finishing frame", g(), 9'h002);
      step(5);  chk(g() == 9'h001, "R5 frame back after flag", g(), 9'h001);
      fe_req = 5'h1C; tag = "R4";
      step(5);  chk(g() == 9'h020, "R4 cpu above subcode", g(), 9'h020);
      cpu_req = 0;
      step(5);  chk(g() == 9'h004, "R4 subcode after cpu", g(), 9'h004);
      fe_req = 5'h00;
      step(5);  chk(g() == 9'h040, "R4 scsi above ecc", g(), 9'h040);
      tag = "R5";
      step(5);  chk(g() == 9'h080, "R5 ecc after single scsi access", g(), 9'h080);
      step(5);  chk(g() == 9'h040, "R5 scsi again after ecc", g(), 9'h040);

      // R6: bursts and pre-emption
      do_reset(); tag = "R6";
      scsi_req = 1; scsi_burst = 1; ecc_req = 1;
      step(1);  chk(g() == 9'h040, "R6 scsi burst start", g(), 9'h040);
      step(5);  chk(g() == 9'h040, "R6 scsi burst continues", g(), 9'h040);
      cpu_req = 1;
      step(5);  chk(g() == 9'h020, "R6 cpu pre-empts burst", g(), 9'h020);
      cpu_req = 0;
      step(5);  chk(g() == 9'h040, "R6 scsi resumes", g(), 9'h040);
      scsi_req = 0; scsi_burst = 0; ecc_burst = 1;
      step(5);  chk(g() == 9'h080, "R6 ecc burst start", g(), 9'h080);
      step(5);  chk(g() == 9'h080, "R6 ecc burst continues", g(), 9'h080);

      // R7: refresh interval and pre-emption of a running ECC burst
      tag = "R7";
      seen = -1;
      for (int i = 0; i < RF + 20; i++) begin
         step(1);
         if (rfsh_gnt && seen < 0) seen = i;
      end
      chk(seen >= 0, "R7 refresh granted within interval", 9'(seen >= 0), 9'd1);
      chk(g() == 9'h080, "R7 ecc burst back after refresh", g(), 9'h080);
      ecc_req = 0; ecc_burst = 0;
      step(10);
      chk(g() == 9'd0, "R8 idle after ecc leaves", g(), 9'd0);

      // R4: pseudo-random traffic compared every cycle
      do_reset(); tag = "R4";
      lf = 32'hACE1_2345;
      for (int i = 0; i < 3000; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         fe_req = lf[4:0] & lf[9:5] & lf[14:10];
         cpu_req = lf[15] & lf[16];
         scsi_req = lf[17]; scsi_burst = lf[18];
         ecc_req = lf[19]; ecc_burst = lf[20];
         step(1);
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule